// File: doc/BRIEF.md
# SDRAM Power-Up and Single-Byte Write Sequencer

This block drives one single-data-rate SDRAM device that has an 8-bit data bus and holds a 512 by 512 byte image. After reset it waits out the device's power-up time. It then runs the initialisation steps: a set of auto-refresh commands, a precharge of every bank, and a mode-register load. The mode it loads gives full-page sequential read bursts with CAS latency 2, and makes writes touch a single location. After that it serves client requests one at a time.

A request is either a byte write or one of three raw commands: open a row, start a burst read, or close the open row. A byte write carries a 9-bit row, a 9-bit column and a data byte. It is carried out as a complete open, write and close cycle, so no row stays open afterwards. While the controller waits for work, it keeps the device refreshed by issuing auto-refresh. It stops doing so while a client has left a row open.

The command pins come straight from the control state. The data bus is split into an output word and an output enable, and the enable is raised only in the cycle that carries the write command.

Top module: `sdramByteSeq`

## Requirements
- R1: While rstN is low the device sees NOP, sdDqm is high, sdDqOe is low and reqReady is low. Once reset is released sdDqm is low. sdCke is high throughout.
- R2: After reset is released the command stays NOP until the clock edge INIT_WAIT cycles later. The first auto-refresh is then visible in the cycle that follows that edge.
- R3: Initialisation issues REF_COUNT auto-refresh commands, each followed by one NOP. Then come precharge with A10 high, NOP, mode-register-set, NOP. The mode-register-set carries address 0x227: A2..A0 = 111 (full page), A3 = 0 (sequential), A6..A4 = 010 (CAS latency 2), A9 = 1 (single-location write), all other bits 0.
- R4: Pins {CS#,RAS#,CAS#,WE#} encode the commands as follows: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001, mode-register-set 0000. The bank pins are always 0.
- R5: reqReady is high only in a NOP cycle while the controller waits. A request is taken on a rising edge where reqValid and reqReady are both high. reqReady then stays low until the sequence and the following idle refresh slot are done. reqKind encodes the request: 0 = byte write, 1 = open row, 2 = burst read, 3 = close row.
- R6: A byte write issues, on consecutive cycles: activate with the row on A8..A0; NOP; write with the column on A8..A0 and A10 low; NOP; precharge with A10 low; NOP. All address bits not named here are 0.
- R7: sdDqOe is high exactly in the cycle that carries the write command, and in that cycle sdDqOut equals the requested byte.
- R8: After every sequence, and while no request arrives, the controller alternates an auto-refresh cycle with a NOP cycle in which reqReady is high.
- R9: An open-row request issues activate with the row. A burst-read request issues read with the column and A10 low. A close-row request issues precharge with A10 low. Each of these is followed by one NOP.
- R10: From an open-row request until the next close-row request, the idle refresh slot carries NOP instead of auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Client request valid |
| reqKind | input | 2 | Request kind: 0 write, 1 open row, 2 burst read, 3 close row |
| reqRow | input | 9 | Row address of the request |
| reqCol | input | 9 | Column address of the request |
| reqData | input | 8 | Byte to write |
| reqReady | output | 1 | Controller can take a request this cycle |
| sdCke | output | 1 | Clock enable to the SDRAM |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdDqm | output | 1 | Data mask |
| sdBank | output | 2 | Bank select |
| sdAddr | output | 12 | Multiplexed address lines |
| sdDqOut | output | 8 | Data driven onto the DQ bus |
| sdDqOe | output | 1 | Output enable for the DQ bus |

## Verification
The bench counts the power-up wait to the exact cycle. A counter off by one would move the first auto-refresh one cycle early or late. It also checks the mode word bit by bit, so a wrong burst, latency or write-mode field shows up as a mismatch on the address lines. The write vectors include the all-ones row, column and data and the all-zero case; a mux that drops a bit or drives A10 during the close step would fail on these. A row deliberately left open checks that idle refresh is suppressed: a controller that ignored the open row would put an auto-refresh on the pins while a bank is active.

// File: rtl/sdramSeqPkg.sv
package sdramSeqPkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_READ, CMD_WRITE, CMD_PRE, CMD_REF, CMD_MRS
  } cmdT;

  typedef enum logic [1:0] {
    ADR_ZERO, ADR_ROW, ADR_COL, ADR_MODE
  } adrSelT;

  typedef enum logic [1:0] {
    REQ_WRITE = 2'd0, REQ_OPEN = 2'd1, REQ_READ = 2'd2, REQ_CLOSE = 2'd3
  } reqKindT;

  typedef struct packed {
    logic   loadReq;
    cmdT    cmd;
    adrSelT adrSel;
    logic   setA10;
    logic   driveDq;
  } strobeT;

  // burst 111, sequential, CAS latency 2, single-location writes
  localparam logic [9:0] MODE_WORD = 10'b10_0010_0111;

endpackage

// File: rtl/sdramSeqCtrl.sv
module sdramSeqCtrl
  import sdramSeqPkg::*;
#(
  parameter int INIT_WAIT = 50000,
  parameter int REF_COUNT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  output logic       reqReady,
  output strobeT     strobe
);

  localparam int WAIT_W = $clog2(INIT_WAIT + 1);
  localparam int REF_W  = $clog2(REF_COUNT + 1);

  typedef enum logic [4:0] {
    sWait, sRef, sRefNop, sPre, sPreNop, sMrs, sMrsNop,
    sIdle, sIdleNop,
    sAct, sActNop, sWr, sWrNop, sPc, sPcNop,
    sOpAct, sOpRd, sOpPre, sOpNop
  } stateT;

  stateT             state, stateNext;
  logic [WAIT_W-1:0] waitCnt;
  logic [REF_W-1:0]  refCnt;
  logic              rowOpen;
  logic              take;

  assign reqReady = (state == sIdleNop);
  assign take     = reqReady && reqValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= sWait;
      waitCnt <= '0;
      refCnt  <= '0;
      rowOpen <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == sWait) waitCnt <= waitCnt + 1'b1;
      if (state == sRefNop) refCnt <= refCnt + 1'b1;
      if (take && reqKindT'(reqKind) == REQ_OPEN)  rowOpen <= 1'b1;
      if (take && reqKindT'(reqKind) == REQ_CLOSE) rowOpen <= 1'b0;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      sWait: if (waitCnt == WAIT_W'(INIT_WAIT - 1)) stateNext = sRef;
      sRef: begin
        strobe.cmd = CMD_REF;
        stateNext  = sRefNop;
      end
      sRefNop: stateNext = (refCnt == REF_W'(REF_COUNT - 1)) ? sPre : sRef;
      sPre: begin
        strobe.cmd    = CMD_PRE;
        strobe.setA10 = 1'b1;
        stateNext     = sPreNop;
      end
      sPreNop: stateNext = sMrs;
      sMrs: begin
        strobe.cmd    = CMD_MRS;
        strobe.adrSel = ADR_MODE;
        stateNext     = sMrsNop;
      end
      sMrsNop: stateNext = sIdle;
      sIdle: begin
        strobe.cmd = rowOpen ? CMD_NOP : CMD_REF;
        stateNext  = sIdleNop;
      end
      sIdleNop: begin
        stateNext = sIdle;
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          unique case (reqKindT'(reqKind))
            REQ_WRITE: stateNext = sAct;
            REQ_OPEN:  stateNext = sOpAct;
            REQ_READ:  stateNext = sOpRd;
            REQ_CLOSE: stateNext = sOpPre;
            default:   stateNext = sIdle;
          endcase
        end
      end
      sAct: begin
        strobe.cmd    = CMD_ACT;
        strobe.adrSel = ADR_ROW;
        stateNext     = sActNop;
      end
      sActNop: stateNext = sWr;
      sWr: begin
        strobe.cmd     = CMD_WRITE;
        strobe.adrSel  = ADR_COL;
        strobe.driveDq = 1'b1;
        stateNext      = sWrNop;
      end
      sWrNop: stateNext = sPc;
      sPc: begin
        strobe.cmd = CMD_PRE;
        stateNext  = sPcNop;
      end
      sPcNop: stateNext = sIdle;
      sOpAct: begin
        strobe.cmd    = CMD_ACT;
        strobe.adrSel = ADR_ROW;
        stateNext     = sOpNop;
      end
      sOpRd: begin
        strobe.cmd    = CMD_READ;
        strobe.adrSel = ADR_COL;
        stateNext     = sOpNop;
      end
      sOpPre: begin
        strobe.cmd = CMD_PRE;
        stateNext  = sOpNop;
      end
      sOpNop:  stateNext = sIdle;
      default: stateNext = sWait;
    endcase
  end

endmodule

// File: rtl/sdramSeqPath.sv
module sdramSeqPath
  import sdramSeqPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqData,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdDqm,
  output logic [1:0]        sdBank,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe
);

  localparam int A10 = 10;

  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic [DATA_W-1:0] dataQ;
  logic [3:0]        pins;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ  <= '0;
      colQ  <= '0;
      dataQ <= '0;
    end else if (strobe.loadReq) begin
      rowQ  <= reqRow;
      colQ  <= reqCol;
      dataQ <= reqData;
    end
  end

  always_comb begin
    sdAddr = '0;
    unique case (strobe.adrSel)
      ADR_ROW:  sdAddr[ROW_W-1:0] = rowQ;
      ADR_COL:  sdAddr[COL_W-1:0] = colQ;
      ADR_MODE: sdAddr[9:0]       = MODE_WORD;
      default:  sdAddr            = '0;
    endcase
    if (strobe.setA10) sdAddr[A10] = 1'b1;
  end

  always_comb begin
    unique case (strobe.cmd)
      CMD_ACT:   pins = 4'b0011;
      CMD_READ:  pins = 4'b0101;
      CMD_WRITE: pins = 4'b0100;
      CMD_PRE:   pins = 4'b0010;
      CMD_REF:   pins = 4'b0001;
      CMD_MRS:   pins = 4'b0000;
      default:   pins = 4'b0111;
    endcase
  end

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = pins;
  assign sdCke   = 1'b1;
  assign sdDqm   = ~rstN;
  assign sdBank  = 2'b00;
  assign sdDqOut = dataQ;
  assign sdDqOe  = strobe.driveDq;

endmodule

// File: rtl/sdramByteSeq.sv
module sdramByteSeq
  import sdramSeqPkg::*;
#(
  parameter int INIT_WAIT = 50000,
  parameter int REF_COUNT = 8,
  parameter int ADDR_W    = 12,
  parameter int ROW_W     = 9,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdDqm,
  output logic [1:0]        sdBank,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe
);

  strobeT strobe;

  sdramSeqCtrl #(.INIT_WAIT(INIT_WAIT), .REF_COUNT(REF_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqReady(reqReady), .strobe(strobe)
  );

  sdramSeqPath #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqRow(reqRow), .reqCol(reqCol), .reqData(reqData),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdDqm(sdDqm), .sdBank(sdBank), .sdAddr(sdAddr),
    .sdDqOut(sdDqOut), .sdDqOe(sdDqOe)
  );

endmodule

// File: rtl/sdramSeqChecker.sv
module sdramSeqChecker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic a10,
  input logic dqOe
);

  logic [3:0] code;
  logic isNop, isAct, isWr, isPre, isRef, openSeen;

  assign code  = {csN, rasN, casN, weN};
  assign isNop = (code == 4'b0111);
  assign isAct = (code == 4'b0011);
  assign isWr  = (code == 4'b0100);
  assign isPre = (code == 4'b0010);
  assign isRef = (code == 4'b0001);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      openSeen <= 1'b0;
    else if (isAct) openSeen <= 1'b1;
    else if (isPre) openSeen <= 1'b0;
  end

  AST_DQ_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN) dqOe |-> isWr); // R7
  AST_WRITE_DRIVES_DQ: assert property (@(posedge clk) disable iff (!rstN) isWr |-> dqOe); // R7
  AST_WRITE_THEN_CLOSE: assert property (@(posedge clk) disable iff (!rstN) isWr |-> ##2 (isPre && !a10)); // R6
  AST_CMD_THEN_NOP: assert property (@(posedge clk) disable iff (!rstN) !isNop |=> isNop); // R8
  AST_READY_ON_NOP: assert property (@(posedge clk) disable iff (!rstN) reqReady |-> isNop); // R5
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN) (reqReady && reqValid) |=> !reqReady); // R5
  AST_NO_REF_OPEN: assert property (@(posedge clk) disable iff (!rstN) isRef |-> !openSeen); // R10

endmodule

bind sdramByteSeq sdramSeqChecker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .csN(sdCsN), .rasN(sdRasN), .casN(sdCasN), .weN(sdWeN),
  .a10(sdAddr[10]), .dqOe(sdDqOe)
);

// File: tb/sdramByteSeq_tb.sv
`timescale 1ns/1ps
module sdramByteSeq_tb;

  localparam int INIT_WAIT = 100;
  localparam int REF_COUNT = 8;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;
  // {row[8:0], col[8:0], data[7:0]}
  localparam logic [25:0] VEC [6] = '{
    {9'd0,   9'd0,   8'h00},
    {9'd511, 9'd511, 8'hFF},
    {9'd1,   9'd256, 8'hA5},
    {9'd256, 9'd1,   8'h5A},
    {9'd170, 9'd341, 8'h3C},
    {9'd341, 9'd170, 8'hC3}
  };

  logic clk = 0, rstN = 0, reqValid = 0;
  logic [1:0] reqKind = 0;
  logic [8:0] reqRow = 0, reqCol = 0;
  logic [7:0] reqData = 0;
  logic reqReady, sdCke, sdCsN, sdRasN, sdCasN, sdWeN, sdDqm, sdDqOe;
  logic [1:0] sdBank;
  logic [11:0] sdAddr;
  logic [7:0] sdDqOut;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdramByteSeq #(.INIT_WAIT(INIT_WAIT), .REF_COUNT(REF_COUNT)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqRow(reqRow), .reqCol(reqCol), .reqData(reqData), .reqReady(reqReady),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdDqm(sdDqm), .sdBank(sdBank), .sdAddr(sdAddr), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe)
  );

  function automatic logic [3:0] code();
    return {sdCsN, sdRasN, sdCasN, sdWeN};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chkCmd(input string req, input string what, input logic [3:0] exp);
    chk(code() == exp && sdBank == 2'b00 && sdCke, req, what, int'(code()), int'(exp));
  endtask

  task automatic handshake(input logic [1:0] kind, input logic [8:0] row, input logic [8:0] col, input logic [7:0] data);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqKind = kind; reqRow = row; reqCol = col; reqData = data;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic doWrite(input logic [8:0] row, input logic [8:0] col, input logic [7:0] data);
    handshake(2'd0, row, col, data);
    chkCmd("R6", "activate", C_ACT);
    chk(sdAddr == {3'b0, row}, "R6", "row address", sdAddr, {3'b0, row});
    chk(!sdDqOe, "R7", "dq idle on activate", sdDqOe, 0);
    @(negedge clk);
    chkCmd("R6", "nop after activate", C_NOP);
    chk(!reqReady, "R5", "ready low in sequence", reqReady, 0);
    @(negedge clk);
    chkCmd("R6", "write", C_WR);
    chk(sdAddr == {3'b0, col}, "R6", "column address", sdAddr, {3'b0, col});
    chk(sdDqOe && sdDqOut == data, "R7", "write data", {sdDqOe, sdDqOut}, {1'b1, data});
    @(negedge clk);
    chkCmd("R6", "nop after write", C_NOP);
    chk(!sdDqOe, "R7", "dq released", sdDqOe, 0);
    @(negedge clk);
    chkCmd("R6", "precharge", C_PRE);
    chk(sdAddr == 12'h0, "R6", "precharge address", sdAddr, 0);
    @(negedge clk);
    chkCmd("R6", "nop after precharge", C_NOP);
    chk(!reqReady, "R5", "ready low before refresh slot", reqReady, 0);
    @(negedge clk);
    chkCmd("R8", "refresh after write", C_REF);
  endtask

  task automatic doOp(input logic [1:0] kind, input logic [8:0] row, input logic [8:0] col,
                      input logic [3:0] expCmd, input logic [11:0] expAddr, input logic [3:0] expIdle);
    handshake(kind, row, col, 8'h77);
    chkCmd("R9", "client command", expCmd);
    chk(sdAddr == expAddr, "R9", "client address", sdAddr, expAddr);
    chk(!sdDqOe, "R7", "dq idle on client op", sdDqOe, 0);
    @(negedge clk);
    chkCmd("R9", "nop after client op", C_NOP);
    @(negedge clk);
    chkCmd("R10", "idle slot after client op", expIdle);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    bit quiet;
    repeat (3) @(negedge clk);
    // R1 reset state
    chkCmd("R1", "nop in reset", C_NOP);
    chk(sdDqm && !sdDqOe && !reqReady, "R1", "dqm/oe/ready in reset",
        {sdDqm, sdDqOe, reqReady}, 3'b100);
    rstN = 1;
    // R2 power-up wait
    quiet = 1;
    for (int i = 1; i < INIT_WAIT; i++) begin
      @(negedge clk);
      if (code() != C_NOP) quiet = 0;
    end
    chk(quiet, "R2", "nop during power-up wait", quiet, 1);
    chk(!sdDqm, "R1", "dqm low after reset", sdDqm, 0);
    @(negedge clk);
    // R3 init
    for (int r = 0; r < REF_COUNT; r++) begin
      chkCmd("R3", "init refresh", C_REF);
      @(negedge clk);
      chkCmd("R3", "nop after init refresh", C_NOP);
      @(negedge clk);
    end
    chkCmd("R3", "precharge all", C_PRE);
    chk(sdAddr == 12'h400, "R3", "precharge all A10", sdAddr, 12'h400);
    @(negedge clk);
    chkCmd("R3", "nop after precharge all", C_NOP);
    @(negedge clk);
    chkCmd("R4", "mode register set", C_MRS);
    chk(sdAddr == 12'h227, "R3", "mode word", sdAddr, 12'h227);
    @(negedge clk);
    chkCmd("R3", "nop after mode set", C_NOP);
    @(negedge clk);
    chkCmd("R8", "first idle refresh", C_REF);
    @(negedge clk);
    chk(reqReady && code() == C_NOP, "R5", "ready in idle nop", reqReady, 1);
    // R8 idle alternation without requests
    @(negedge clk);
    chkCmd("R8", "idle refresh repeats", C_REF);
    chk(!reqReady, "R5", "ready low in refresh slot", reqReady, 0);
    @(negedge clk);
    chk(reqReady && code() == C_NOP, "R8", "idle nop with ready", {reqReady, code()}, {1'b1, C_NOP});
    // R6 R7 vector table of byte writes
    for (int v = 0; v < 6; v++) doWrite(VEC[v][25:17], VEC[v][16:8], VEC[v][7:0]);
    // R9 R10 client commands
    doOp(2'd1, 9'h155, 9'h0, C_ACT, 12'h155, C_NOP);
    quiet = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (code() == C_REF) quiet = 0;
    end
    chk(quiet, "R10", "no refresh while row open", quiet, 1);
    doOp(2'd2, 9'h0, 9'h1AA, C_RD, 12'h1AA, C_NOP);
    doOp(2'd3, 9'h1FF, 9'h1FF, C_PRE, 12'h000, C_REF);
    @(negedge clk);
    @(negedge clk);
    chkCmd("R10", "refresh resumes after close", C_REF);
    doWrite(9'h0AB, 9'h1CD, 8'h81);
    done = 1;
    finishRun();
  end

endmodule